// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Engine

This block converts host register accesses into byte transfers on a peripheral handshake link. It sits beside the printer port register file. It takes the current control register contents and the live printer status byte as plain inputs. An access to the address-cycle offset produces one address transfer. An access to the data-cycle offset produces one, two or four data transfers, least significant byte first. Each transfer is held on the link until the peripheral acknowledges it. The acknowledge carries an error flag.

A transfer starts only when the control bits that select direction and drive the printer signal lines hold exactly the pattern for that direction. Any other pattern drops a write without a trace, and a read returns all ones at the access width. A peripheral error ends the sequence at once and sets a sticky timeout flag. Status register reads show that flag in bit 0. Writing a 1 to that bit clears the flag.

The host side is a valid/ready request channel. The host raises `host_valid` with the request fields and holds them unchanged. The block keeps `host_ready` low as back-pressure until the whole byte sequence has finished. It then raises `host_ready` for exactly one cycle, and `host_rdata` is valid in that cycle. The host must drop `host_valid` or present a new request after that cycle, because a request still present in the next cycle counts as a new access.

Top module: `epp_cycle_unit`

## Requirements
- R1: After reset, `host_ready`, `pc_req` and `timeout_flag` are all 0.
- R2: Offset 3 runs exactly one transfer with `pc_addr_cycle`=1, whatever the size code. Offset 4 runs data transfers with `pc_addr_cycle`=0.
- R3: A write at offset 3 or 4 runs only if `(ctrl_bits & 8'h2F) == 8'h04`. Otherwise no transfer is issued and the access still completes.
- R4: A read at offset 3 or 4 runs only if `(ctrl_bits & 8'h2F) == 8'h24`. Otherwise no transfer is issued and `host_rdata` is all ones in the low N bytes and zero above them.
- R5: At offset 4, `host_size` 0, 1 and 2 (or 3) select N = 1, 2 and 4 bytes. Byte k of `host_wdata` (bits 8k+7:8k) is the k-th transfer sent. The k-th byte received lands in bits 8k+7:8k of `host_rdata`. Bits above byte N-1 read 0.
- R6: A transfer acknowledged with `pc_err`=1 sets `timeout_flag` and ends the access. No further bytes are issued. The received bytes of a read keep their values, and bytes not yet received read 8'hFF.
- R7: A read at offset 1 returns `{stat_bits[7:1], timeout_flag}` in the low byte, with zeros above it.
- R8: A write at offset 1 with `host_wdata[0]`=1 clears `timeout_flag`. With bit 0 = 0 the flag is unchanged.
- R9: `host_ready` is high for exactly one cycle per accepted request. `pc_req`, `pc_wdata`, `pc_write` and `pc_addr_cycle` hold steady until `pc_ack`.
- R10: Offsets 0, 2, 5, 6 and 7 complete with no transfer. A read at one of these offsets returns 8'hFF in the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_bits | input | 8 | Current printer control register value |
| stat_bits | input | 8 | Current printer status byte |
| host_valid | input | 1 | Request present |
| host_ready | output | 1 | One-cycle completion of the request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_ofs | input | 3 | Register offset |
| host_size | input | 2 | Size code for offset 4 |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, valid while host_ready |
| pc_req | output | 1 | Peripheral transfer request |
| pc_ack | input | 1 | Peripheral acknowledge |
| pc_err | input | 1 | Error flag, sampled with pc_ack |
| pc_addr_cycle | output | 1 | 1 = address transfer, 0 = data transfer |
| pc_write | output | 1 | Transfer direction, 1 = to peripheral |
| pc_wdata | output | 8 | Byte sent to the peripheral |
| pc_rdata | input | 8 | Byte from the peripheral, sampled with pc_ack |
| timeout_flag | output | 1 | Sticky timeout flag |

## Verification
Several properties are checked on every clock cycle. Each peripheral request stays steady until its acknowledge, and `host_ready` never lasts longer than one cycle. A request may only start after a cycle in which the gate allowed the chosen direction. The timeout flag may rise only after an errored acknowledge and fall only after a clearing status write. The bench scenarios show the rest: the byte order of wide transfers, the all-ones width of gated or cut-short reads, the count of transfers issued (none when gated), and the bit 0 merge on status reads.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} epp_state_e;

  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_ADDR = 3'd3;
  localparam logic [2:0] OFS_DATA = 3'd4;

  // direction bit plus the four printer signal lines
  localparam logic [7:0] GATE_MASK = 8'h2F;
  localparam logic [7:0] GATE_WR   = 8'h04;
  localparam logic [7:0] GATE_RD   = 8'h24;
endpackage

// File: rtl/epp_gate.sv
module epp_gate
  import epp_pkg::*;
(
  input  logic [7:0] ctrl_bits,
  output logic       wr_ok,
  output logic       rd_ok
);
  logic [7:0] masked;
  assign masked = ctrl_bits & GATE_MASK;
  assign wr_ok  = (masked == GATE_WR);   // R3
  assign rd_ok  = (masked == GATE_RD);   // R4
endmodule

// File: rtl/epp_timeout_flag.sv
module epp_timeout_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  // R8: the flag drops only after a clearing status write
  p_clear_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_o) |-> $past(clr_i));
endmodule

// File: rtl/epp_rd_lanes.sv
module epp_rd_lanes #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_val,
  input  logic              cap_en,
  input  logic [IDX_W-1:0]  cap_idx,
  input  logic [7:0]        cap_byte,
  output logic [DATA_W-1:0] rdata
);
  localparam int NBYTES = DATA_W / 8;

  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                    lane_q <= 8'h00;
      else if (load_en)                              lane_q <= load_val[k*8 +: 8];
      else if (cap_en && cap_idx == IDX_W'(k))       lane_q <= cap_byte;
    end
    assign rdata[k*8 +: 8] = lane_q;
  end
endmodule

// File: rtl/epp_cycle_unit.sv
module epp_cycle_unit
  import epp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        ctrl_bits,
  input  logic [7:0]        stat_bits,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_write,
  input  logic [2:0]        host_ofs,
  input  logic [1:0]        host_size,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              pc_req,
  input  logic              pc_ack,
  input  logic              pc_err,
  output logic              pc_addr_cycle,
  output logic              pc_write,
  output logic [7:0]        pc_wdata,
  input  logic [7:0]        pc_rdata,
  output logic              timeout_flag
);
  localparam int NBYTES = DATA_W / 8;
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int SZ_MAX = $clog2(NBYTES);

  epp_state_e        state;
  logic [IDX_W-1:0]  idx, last_idx;
  logic              op_write, op_addr;
  logic [DATA_W-1:0] wbuf;

  logic              wr_ok, rd_ok;
  logic              accept, run_now;
  logic [IDX_W:0]    nb;
  logic [DATA_W-1:0] ones_mask, load_val;
  logic              load_en, cap_en, to_set, to_clr;

  epp_gate u_gate (.ctrl_bits(ctrl_bits), .wr_ok(wr_ok), .rd_ok(rd_ok));

  epp_timeout_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(to_set), .clr_i(to_clr), .flag_o(timeout_flag)
  );

  epp_rd_lanes #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_lanes (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
    .cap_en(cap_en), .cap_idx(idx), .cap_byte(pc_rdata), .rdata(host_rdata)
  );

  assign accept = (state == ST_IDLE) && host_valid;

  // byte count of the access: address cycles are always one byte
  always_comb begin
    if (host_ofs != OFS_DATA)            nb = (IDX_W+1)'(1);
    else if (int'(host_size) >= SZ_MAX)  nb = (IDX_W+1)'(NBYTES);
    else                                 nb = (IDX_W+1)'(1) << host_size;
  end

  always_comb begin
    for (int k = 0; k < NBYTES; k++)
      ones_mask[k*8 +: 8] = ((IDX_W+1)'(k) < nb) ? 8'hFF : 8'h00;
  end

  always_comb begin
    run_now = 1'b0;
    if (host_ofs == OFS_ADDR || host_ofs == OFS_DATA)
      run_now = host_write ? wr_ok : rd_ok;
  end

  always_comb begin
    load_val = ones_mask;
    if (host_ofs == OFS_STAT && !host_write)
      load_val = {{(DATA_W-8){1'b0}}, (stat_bits & 8'hFE) | {7'd0, timeout_flag}};
  end

  assign load_en = accept;
  assign cap_en  = (state == ST_RUN) && pc_ack && !op_write;
  assign to_set  = (state == ST_RUN) && pc_ack && pc_err;
  assign to_clr  = accept && host_write && host_ofs == OFS_STAT && host_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      idx      <= '0;
      last_idx <= '0;
      op_write <= 1'b0;
      op_addr  <= 1'b0;
      wbuf     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (host_valid) begin
          idx      <= '0;
          last_idx <= IDX_W'(nb - 1'b1);
          op_write <= host_write;
          op_addr  <= (host_ofs == OFS_ADDR);
          wbuf     <= host_wdata;
          state    <= run_now ? ST_RUN : ST_DONE;
        end
        ST_RUN: if (pc_ack) begin
          if (pc_err || idx == last_idx) state <= ST_DONE;
          else                           idx   <= idx + 1'b1;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign host_ready    = (state == ST_DONE);
  assign pc_req        = (state == ST_RUN);
  assign pc_write      = op_write;
  assign pc_addr_cycle = op_addr;
  assign pc_wdata      = wbuf[idx*8 +: 8];

  // R9: a request and its byte hold until acknowledged
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_req && !pc_ack |=> pc_req && $stable(pc_wdata) && $stable(pc_addr_cycle) && $stable(pc_write));
  // R9: completion is a single-cycle pulse
  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready);
  p_ready_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> !pc_req);
  // R3/R4: a sequence starts only after the gate allowed its direction
  p_gate_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pc_req) |-> $past(host_write ? wr_ok : rd_ok));
  // R6: the flag rises only after an errored acknowledge
  p_timeout_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> $past(pc_ack && pc_err && pc_req));
endmodule

// File: tb/epp_cycle_unit_tb.sv
module epp_cycle_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ctrl_bits = 8'hC4;
  logic [7:0]  stat_bits = 8'hD9;
  logic        host_valid = 1'b0, host_write = 1'b0;
  logic [2:0]  host_ofs = 3'd0;
  logic [1:0]  host_size = 2'd0;
  logic [31:0] host_wdata = 32'd0;
  logic        host_ready;
  logic [31:0] host_rdata;
  logic        pc_req, pc_addr_cycle, pc_write;
  logic [7:0]  pc_wdata;
  logic        pc_ack = 1'b0, pc_err = 1'b0;
  logic [7:0]  pc_rdata = 8'h00;
  logic        timeout_flag;

  always #4 clk = ~clk;

  epp_cycle_unit dut_i (.*);

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // scoreboard
  logic [31:0] exp_q[$];
  bit          chk_q[$];
  string       tag_q[$];

  // peripheral model
  int          dly = 0, wait_c = 0, byte_cnt = 0, err_at = 99;
  logic [7:0]  rd_base = 8'h10;
  logic [9:0]  xlog[$];

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      pc_ack = 1'b0; wait_c = 0;
    end else if (pc_ack) begin
      pc_ack = 1'b0; pc_err = 1'b0;
    end else if (pc_req) begin
      if (wait_c < dly) wait_c++;
      else begin
        wait_c   = 0;
        pc_ack   = 1'b1;
        pc_err   = (byte_cnt == err_at);
        pc_rdata = rd_base + 8'(byte_cnt);
        xlog.push_back({pc_write, pc_addr_cycle, pc_write ? pc_wdata : pc_rdata});
        byte_cnt++;
      end
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && host_ready && exp_q.size() > 0) begin
      logic [31:0] e; bit c; string t;
      e = exp_q.pop_front(); c = chk_q.pop_front(); t = tag_q.pop_front();
      if (c) check(host_rdata === e, t, host_rdata, e);
    end
  end

  task automatic access(bit wr, logic [2:0] ofs, logic [1:0] sz, logic [31:0] wd,
                        bit chk, logic [31:0] exp, string req);
    exp_q.push_back(exp); chk_q.push_back(chk); tag_q.push_back(req);
    byte_cnt = 0; xlog.delete();
    host_valid = 1'b1; host_write = wr; host_ofs = ofs; host_size = sz; host_wdata = wd;
    do @(negedge clk); while (!host_ready);
    host_valid = 1'b0;
    @(negedge clk);
    check(host_ready === 1'b0, "R9", 32'(host_ready), 32'd0);
  endtask

  // expected transfer log: n entries, data bytes packed low first
  task automatic check_log(int n, bit wr, bit adr, logic [31:0] bytes, string req);
    check(xlog.size() == n, req, 32'(xlog.size()), 32'(n));
    for (int i = 0; i < n && i < xlog.size(); i++)
      check(xlog[i] === {wr, adr, bytes[i*8 +: 8]}, req, 32'(xlog[i]),
            32'({wr, adr, bytes[i*8 +: 8]}));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(host_ready === 1'b0, "R1", 32'(host_ready), 32'd0);
    check(pc_req === 1'b0, "R1", 32'(pc_req), 32'd0);
    check(timeout_flag === 1'b0, "R1", 32'(timeout_flag), 32'd0);

    // R7: status read replaces bit 0 with the (clear) flag
    access(0, 3'd1, 2'd0, 0, 1, 32'h0000_00D8, "R7");

    // write gate open, address cycle with a wide size code: one byte
    ctrl_bits = 8'hC4;
    access(1, 3'd3, 2'd2, 32'h7788_995A, 0, 0, "R2");
    check_log(1, 1, 1, 32'h0000_005A, "R2");
    access(1, 3'd4, 2'd1, 32'h0000_1234, 0, 0, "R5");
    check_log(2, 1, 0, 32'h0000_1234, "R5");
    access(1, 3'd4, 2'd2, 32'hA1B2_C3D4, 0, 0, "R5");
    check_log(4, 1, 0, 32'hA1B2_C3D4, "R5");
    dly = 3;
    access(1, 3'd4, 2'd0, 32'h0000_00EE, 0, 0, "R9");
    check_log(1, 1, 0, 32'h0000_00EE, "R9");
    dly = 0;

    // R4: reads gated off while in write configuration
    access(0, 3'd4, 2'd2, 0, 1, 32'hFFFF_FFFF, "R4");
    check_log(0, 0, 0, 0, "R4");
    access(0, 3'd4, 2'd1, 0, 1, 32'h0000_FFFF, "R4");
    access(0, 3'd3, 2'd0, 0, 1, 32'h0000_00FF, "R4");
    check_log(0, 0, 0, 0, "R4");

    // R3: writes dropped when the pattern is wrong
    ctrl_bits = 8'hE4;
    access(1, 3'd4, 2'd2, 32'h1111_2222, 0, 0, "R3");
    check_log(0, 1, 0, 0, "R3");
    ctrl_bits = 8'h0C;
    access(1, 3'd3, 2'd0, 32'h33, 0, 0, "R3");
    check_log(0, 1, 1, 0, "R3");

    // reads in read configuration
    ctrl_bits = 8'hE4; rd_base = 8'h10;
    access(0, 3'd4, 2'd2, 0, 1, 32'h1312_1110, "R5");
    check_log(4, 0, 0, 32'h1312_1110, "R5");
    rd_base = 8'h40;
    access(0, 3'd3, 2'd2, 0, 1, 32'h0000_0040, "R2");
    check_log(1, 0, 1, 32'h0000_0040, "R2");
    access(0, 3'd4, 2'd1, 0, 1, 32'h0000_4140, "R5");

    // R6: error on the second byte of a wide read
    rd_base = 8'h20; err_at = 1;
    access(0, 3'd4, 2'd3, 0, 1, 32'hFFFF_2120, "R6");
    check(xlog.size() == 2, "R6", 32'(xlog.size()), 32'd2);
    check(timeout_flag === 1'b1, "R6", 32'(timeout_flag), 32'd1);
    err_at = 99;
    stat_bits = 8'hD8;
    access(0, 3'd1, 2'd0, 0, 1, 32'h0000_00D9, "R7");

    // R8: bit 0 clear leaves flag, bit 0 set clears it
    access(1, 3'd1, 2'd0, 32'hFE, 0, 0, "R8");
    access(0, 3'd1, 2'd0, 0, 1, 32'h0000_00D9, "R8");
    access(1, 3'd1, 2'd0, 32'h01, 0, 0, "R8");
    access(0, 3'd1, 2'd0, 0, 1, 32'h0000_00D8, "R8");

    // R6: write error on the first byte stops the sequence
    ctrl_bits = 8'h04; err_at = 0;
    access(1, 3'd4, 2'd2, 32'h5566_7788, 0, 0, "R6");
    check_log(1, 1, 0, 32'h0000_0088, "R6");
    check(timeout_flag === 1'b1, "R6", 32'(timeout_flag), 32'd1);
    err_at = 99;

    // R10: foreign offsets
    access(0, 3'd2, 2'd2, 0, 1, 32'h0000_00FF, "R10");
    access(1, 3'd0, 2'd0, 32'h99, 0, 0, "R10");
    check_log(0, 1, 0, 0, "R10");
    access(0, 3'd7, 2'd0, 0, 1, 32'h0000_00FF, "R10");

    check(exp_q.size() == 0, "R9", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule